// File: doc/BRIEF.md
# FIFO Event and Interrupt Unit

This block sits between a host register port and a serial shifter. It holds two byte-wide FIFOs: one filled by the host and drained one byte at a time by the shifter, and one filled one byte at a time by the shifter and drained by the host. The host sees four registers, selected by a 2-bit address: the event word (address 0), the interrupt mask (address 1), the transmit data port (address 2) and the receive data port (address 3).

The event word reports the current byte count of each FIFO next to two sticky flags: "receive holds data" and "transmit has room". A flag is cleared by writing 1 to its bit. The mask register enables each flag onto a single registered interrupt line. The host accesses the data ports either as a 32-bit word, which moves four bytes with the oldest byte in bits 31:24, or as a single byte in bits 7:0.

Top module: `fifo_evt_unit`

## Requirements
- R1: While reset is held and in the first cycle after its release, the event word reads 0, the mask reads 0, `irq` is 0 and `tx_avail` is 0.
- R2: The event word (address 0) carries the receive FIFO byte count in bits 29:24 and the transmit FIFO byte count in bits 21:16. Both counts are live, range 0 to 32, and every other bit apart from bits 9 and 8 reads 0.
- R3: Event bit 9 ("receive holds data") is set at every clock edge where the receive FIFO is non-empty. It stays set until it is cleared, and if the receive FIFO is still non-empty it is set again at the edge that follows the clear.
- R4: Event bit 8 ("transmit has room") behaves in the same way, driven by the transmit FIFO holding fewer than 32 bytes.
- R5: The mask register (address 1) holds enables in bits 9 and 8 and reads back in those positions. `irq` is the OR of (event bit AND mask bit), registered, so it follows one cycle after its cause. A mask of 0 keeps `irq` low.
- R6: A 32-bit write to address 2 pushes four bytes, bits 31:24 first. The shifter sees the oldest byte on `tx_byte` while `tx_avail` is high, and `tx_pop` removes it.
- R7: A 32-bit transmit write is ignored when fewer than four bytes are free. An 8-bit transmit write (`host_byte`=1) pushes bits 7:0 and is ignored when the FIFO is full.
- R8: A 32-bit read of address 3 returns up to four bytes, oldest in bits 31:24, and pops them. When fewer than four bytes are held, only those bytes are returned and popped, and the missing lower byte positions read 0.
- R9: An 8-bit read of address 3 returns the oldest byte in bits 7:0 with the upper bits 0 and pops one byte. On an empty FIFO it returns 0 and changes nothing.
- R10: A byte pushed by the shifter (`rx_push`) into a full receive FIFO is dropped, and the count stays at 32.
- R11: A write to the event word clears only the event bits written as 1. Bits written as 0 are unaffected, and the mask is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 event, 1 mask, 2 transmit data, 3 receive data |
| host_byte | input | 1 | 1 = 8-bit data access, 0 = 32-bit |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the access cycle |
| irq | output | 1 | Registered interrupt request |
| tx_pop | input | 1 | Shifter consumes the oldest transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit FIFO non-empty |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |

## Verification
A pointer or count that goes wrong shows up in the count fields of the event word at the very next read. It also shows up on `tx_byte` in the same cycle, and as wrong byte order in the next receive read. A sticky flag that fails to re-set, or that ignores a clear, is visible in the event word one cycle after the write. A wrong interrupt gate is visible on `irq` one cycle after the event or mask change. The bench compares every output on every cycle against a byte-queue model, so each of these faults is reported within a cycle or two of its cause.

// File: rtl/fevu_pkg.sv
package fevu_pkg;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned CNT_FIELD_W = 6;
  localparam int unsigned RXCNT_LSB   = 24;
  localparam int unsigned TXCNT_LSB   = 16;
  localparam int unsigned EV_LSB      = 8;   // bit 8 tx room, bit 9 rx data
  localparam int unsigned NUM_EV      = 2;

  typedef enum logic [1:0] {
    REG_EVENT = 2'd0,
    REG_MASK  = 2'd1,
    REG_TXD   = 2'd2,
    REG_RXD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fevu_byte_fifo.sv
// Byte FIFO with multi-byte push per cycle and a multi-byte head window.
// DEPTH must be a power of two; pointers wrap naturally.
module fevu_byte_fifo #(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned LANES      = 4,
  parameter int unsigned PEEK_LANES = 4,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned NW = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NW-1:0]           push_n,
  input  logic [8*LANES-1:0]      push_data,
  input  logic [NW-1:0]           pop_n,
  output logic [8*PEEK_LANES-1:0] peek_data,
  output logic [CW-1:0]           count
);
  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q + PW'(push_n);
    rp_d  = rp_q + PW'(pop_n);
    cnt_d = cnt_q + CW'(push_n) - CW'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage: lane k of push_data (k=0 at the top) lands at wp+k.
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (NW'(k) < push_n) begin
        mem_q[wp_q + PW'(k)] <= push_data[8*(LANES-1-k) +: 8];
      end
    end
  end

  for (genvar k = 0; k < PEEK_LANES; k++) begin : g_peek
    assign peek_data[8*(PEEK_LANES-1-k) +: 8] =
      (CW'(k) < cnt_q) ? mem_q[rp_q + PW'(k)] : 8'h00;
  end

  assign count = cnt_q;

  // R10: occupancy never exceeds the depth
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R8: never pop more bytes than are held
  assert_pop_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= cnt_q);
  // R7: never push past the free space
  assert_push_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(push_n) + cnt_q) <= CW'(DEPTH));
endmodule

// File: rtl/fevu_evt_irq.sv
// Sticky write-1-clear event bits, mask register and registered interrupt.
module fevu_evt_irq #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cond,
  input  logic [NSRC-1:0] clr,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wd,
  output logic [NSRC-1:0] ev,
  output logic [NSRC-1:0] mask,
  output logic            irq
);
  logic [NSRC-1:0] ev_q, ev_d, mask_q, mask_d;
  logic            irq_q, irq_d;

  always_comb begin
    ev_d   = (ev_q | cond) & ~clr;          // clear wins in its own cycle
    mask_d = mask_we ? mask_wd : mask_q;
    irq_d  = |(ev_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ev_q   <= ev_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign ev   = ev_q;
  assign mask = mask_q;
  assign irq  = irq_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // R11: a bit written 1 reads clear after the write
    assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !ev_q[i]);
    // R3 / R4: a live condition sets its bit unless cleared in that cycle
    assert_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cond[i] && !clr[i]) |=> ev_q[i]);
  end

  // R5: a zero mask keeps the line low
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_q);
  // R5: the line only rises after an enabled event
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|(ev_q & mask_q)));
endmodule

// File: rtl/fifo_evt_unit.sv
module fifo_evt_unit
  import fevu_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic        host_byte,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        irq,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_avail,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned NW = $clog2(WORD_BYTES + 1);
  localparam int unsigned BW = 8 * WORD_BYTES;

  reg_sel_e sel_reg;
  logic     wr_evt, wr_mask, wr_tx, rd_rx;

  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic [NW-1:0] tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [BW-1:0] tx_push_data, rx_push_data, rx_peek;
  logic [7:0]    tx_peek;
  logic [NUM_EV-1:0] ev_cond, ev_clr, ev_bits, mask_bits;

  assign sel_reg = reg_sel_e'(host_addr);
  assign wr_evt  = host_sel &  host_wr && (sel_reg == REG_EVENT);
  assign wr_mask = host_sel &  host_wr && (sel_reg == REG_MASK);
  assign wr_tx   = host_sel &  host_wr && (sel_reg == REG_TXD);
  assign rd_rx   = host_sel & !host_wr && (sel_reg == REG_RXD);
  assign tx_free = CW'(DEPTH) - tx_cnt;

  // Push / pop sizing, all judged on the counts before this edge.
  always_comb begin
    tx_push_n = '0;
    if (wr_tx) begin
      if (host_byte) begin
        if (tx_free != '0) tx_push_n = NW'(1);
      end else begin
        if (tx_free >= CW'(WORD_BYTES)) tx_push_n = NW'(WORD_BYTES);
      end
    end
    tx_pop_n  = (tx_pop && tx_cnt != '0) ? NW'(1) : '0;
    rx_push_n = (rx_push && rx_cnt != CW'(DEPTH)) ? NW'(1) : '0;
    rx_pop_n  = '0;
    if (rd_rx) begin
      if (host_byte) begin
        if (rx_cnt != '0) rx_pop_n = NW'(1);
      end else if (rx_cnt >= CW'(WORD_BYTES)) begin
        rx_pop_n = NW'(WORD_BYTES);
      end else begin
        rx_pop_n = NW'(rx_cnt);
      end
    end
  end

  assign tx_push_data = host_byte ? {host_wdata[7:0], {(BW-8){1'b0}}} : host_wdata;
  assign rx_push_data = {rx_byte, {(BW-8){1'b0}}};

  fevu_byte_fifo #(.DEPTH(DEPTH), .LANES(WORD_BYTES), .PEEK_LANES(1)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_n(tx_push_n), .push_data(tx_push_data),
    .pop_n(tx_pop_n), .peek_data(tx_peek), .count(tx_cnt)
  );

  fevu_byte_fifo #(.DEPTH(DEPTH), .LANES(WORD_BYTES), .PEEK_LANES(WORD_BYTES)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_n(rx_push_n), .push_data(rx_push_data),
    .pop_n(rx_pop_n), .peek_data(rx_peek), .count(rx_cnt)
  );

  // Index 1 = receive holds data (bit 9), index 0 = transmit has room (bit 8)
  assign ev_cond = {rx_cnt != '0, tx_cnt != CW'(DEPTH)};
  assign ev_clr  = wr_evt ? host_wdata[EV_LSB +: NUM_EV] : '0;

  fevu_evt_irq #(.NSRC(NUM_EV)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .cond(ev_cond), .clr(ev_clr),
    .mask_we(wr_mask), .mask_wd(host_wdata[EV_LSB +: NUM_EV]),
    .ev(ev_bits), .mask(mask_bits), .irq(irq)
  );

  always_comb begin
    host_rdata = '0;
    unique case (sel_reg)
      REG_EVENT: begin
        host_rdata[RXCNT_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(rx_cnt);
        host_rdata[TXCNT_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(tx_cnt);
        host_rdata[EV_LSB +: NUM_EV]         = ev_bits;
      end
      REG_MASK: host_rdata[EV_LSB +: NUM_EV] = mask_bits;
      REG_TXD:  host_rdata = '0;
      REG_RXD:  host_rdata = host_byte ? {{(BW-8){1'b0}}, rx_peek[BW-1 -: 8]} : rx_peek;
      default:  host_rdata = '0;
    endcase
  end

  assign tx_byte  = tx_peek;
  assign tx_avail = (tx_cnt != '0);

  // R7: a word write without four free bytes leaves the count alone
  assert_tx_word_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && !host_byte && tx_free < CW'(WORD_BYTES) && !tx_pop) |=> $stable(tx_cnt));
  // R10: a push into a full receive FIFO is dropped
  assert_rx_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == CW'(DEPTH) && !rd_rx) |=> $stable(rx_cnt));
  // R9: a byte read of an empty receive FIFO changes nothing
  assert_empty_byte_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && host_byte && rx_cnt == '0 && !rx_push) |=> (rx_cnt == '0));
endmodule

// File: tb/tb_fifo_evt_unit.sv
`timescale 1ns/100ps
module tb_fifo_evt_unit;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_wr, host_byte;
  logic [1:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        irq, tx_pop, tx_avail, rx_push;
  logic [7:0]  tx_byte, rx_byte;

  always #2.5 clk = ~clk;

  fifo_evt_unit #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_byte(host_byte), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail),
    .rx_push(rx_push), .rx_byte(rx_byte)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  byte unsigned txq[$];
  byte unsigned rxq[$];
  logic [1:0]   ev_m, mask_m;
  logic         irq_m;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_event();
    return {2'b00, 6'(rxq.size()), 2'b00, 6'(txq.size()), 6'b0, ev_m, 8'h00};
  endfunction

  function automatic logic [31:0] exp_rx(input bit bsz);
    logic [31:0] v = '0;
    if (bsz) begin
      if (rxq.size() > 0) v[7:0] = rxq[0];
    end else begin
      for (int k = 0; k < 4; k++)
        if (k < rxq.size()) v[31-8*k -: 8] = rxq[k];
    end
    return v;
  endfunction

  // One clock cycle: drive at the falling edge, check 1 ns later,
  // advance the model for the rising edge, return at the next falling edge.
  task automatic op(input bit sel, input bit wr, input logic [1:0] addr, input bit bsz,
                    input logic [31:0] wd, input bit tp, input bit rp,
                    input logic [7:0] rb, input string tag);
    int tsz, rsz, n;
    logic [1:0] cnd, clr;
    host_sel = sel; host_wr = wr; host_addr = addr; host_byte = bsz;
    host_wdata = wd; tx_pop = tp; rx_push = rp; rx_byte = rb;
    #1;
    chk({31'b0, irq}, {31'b0, irq_m}, {tag, " R5 irq"});
    chk({31'b0, tx_avail}, {31'b0, txq.size() > 0}, {tag, " R6 tx_avail"});
    if (txq.size() > 0) chk({24'b0, tx_byte}, {24'b0, txq[0]}, {tag, " R6 tx_byte order"});
    if (sel && !wr) begin
      case (addr)
        2'd0: chk(host_rdata, exp_event(), {tag, " R2/R3/R4 event word"});
        2'd1: chk(host_rdata, {22'b0, mask_m, 8'h00}, {tag, " R5 mask readback"});
        2'd3: chk(host_rdata, exp_rx(bsz), {tag, bsz ? " R9 rx byte read" : " R8 rx word read"});
        default: ;
      endcase
    end
    // model of the edge
    tsz = txq.size(); rsz = rxq.size();
    irq_m = |(ev_m & mask_m);
    cnd = {rsz > 0, tsz < DEPTH};
    clr = (sel && wr && addr == 2'd0) ? wd[9:8] : 2'b00;
    ev_m = (ev_m | cnd) & ~clr;
    if (sel && wr && addr == 2'd1) mask_m = wd[9:8];
    if (tp && tsz > 0) void'(txq.pop_front());
    if (sel && wr && addr == 2'd2) begin
      if (bsz) begin
        if (tsz < DEPTH) txq.push_back(wd[7:0]);
      end else if (tsz <= DEPTH - 4) begin
        for (int k = 0; k < 4; k++) txq.push_back(wd[31-8*k -: 8]);
      end
    end
    if (sel && !wr && addr == 2'd3) begin
      n = bsz ? (rsz > 0 ? 1 : 0) : (rsz < 4 ? rsz : 4);
      for (int k = 0; k < n; k++) void'(rxq.pop_front());
    end
    if (rp && rsz < DEPTH) rxq.push_back(rb);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    op(0, 0, 2'd0, 0, 32'h0, 0, 0, 8'h00, tag);
  endtask
  task automatic rd(input logic [1:0] a, input bit b, input string tag);
    op(1, 0, a, b, 32'h0, 0, 0, 8'h00, tag);
  endtask
  task automatic wr(input logic [1:0] a, input bit b, input logic [31:0] d, input string tag);
    op(1, 1, a, b, d, 0, 0, 8'h00, tag);
  endtask
  task automatic rx_in(input logic [7:0] b, input string tag);
    op(0, 0, 2'd0, 0, 32'h0, 0, 1, b, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    ev_m = '0; mask_m = '0; irq_m = 1'b0;
    rst_n = 1'b0;
    host_sel = 1; host_wr = 0; host_addr = 2'd0; host_byte = 0;
    host_wdata = '0; tx_pop = 0; rx_push = 0; rx_byte = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(host_rdata, 32'h0, "R1 event word in reset");
    chk({31'b0, irq}, 32'h0, "R1 irq in reset");
    chk({31'b0, tx_avail}, 32'h0, "R1 tx_avail in reset");
    host_addr = 2'd1; #0.5;
    chk(host_rdata, 32'h0, "R1 mask in reset");
    @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, 0, "R1 first cycle");          // still all zero
    rd(2'd0, 0, "R4 tx room set");           // bit 8 now set
    wr(2'd0, 0, 32'h0000_0100, "R11 clear bit8");
    rd(2'd0, 0, "R4 cleared");               // reads 0 in this cycle
    rd(2'd0, 0, "R4 re-set");                // set again
    wr(2'd1, 0, 32'h0000_0300, "R5 mask on");
    idle("R5 irq rises");
    rd(2'd1, 0, "R5 mask read");
    wr(2'd2, 0, 32'hA1B2_C3D4, "R6 word push");
    for (int i = 0; i < 4; i++) op(0, 0, 2'd0, 0, 0, 1, 0, 0, "R6 drain");
    wr(2'd2, 1, 32'hFFFF_FF5A, "R7 byte push");
    rd(2'd0, 0, "R2 tx count 1");
    op(0, 0, 2'd0, 0, 0, 1, 0, 0, "R6 drain byte");
    for (int i = 0; i < 8; i++) wr(2'd2, 0, 32'h1020_3040 + i, "R7 fill");
    rd(2'd0, 0, "R2 tx full");
    wr(2'd2, 0, 32'hDEAD_BEEF, "R7 word when full");
    wr(2'd2, 1, 32'h0000_0077, "R7 byte when full");
    rd(2'd0, 0, "R7 count unchanged");
    op(0, 0, 2'd0, 0, 0, 1, 0, 0, "R7 pop one");
    wr(2'd2, 0, 32'h1111_1111, "R7 word with 1 free");
    wr(2'd2, 1, 32'h0000_0099, "R7 byte with 1 free");
    rd(2'd0, 0, "R7 full again");
    while (txq.size() > 0) op(0, 0, 2'd0, 0, 0, 1, 0, 0, "R6 drain all");
    for (int i = 0; i < 5; i++) rx_in(8'h30 + 8'(i), "R3 rx in");
    rd(2'd0, 0, "R3 rx data flag");
    rd(2'd3, 0, "R8 word of four");
    rd(2'd3, 0, "R8 partial word");
    rd(2'd3, 1, "R9 empty byte read");
    rd(2'd0, 0, "R9 still empty");
    wr(2'd0, 0, 32'hFFFF_FFFF, "R11 clear all");
    rd(2'd0, 0, "R3 stays clear when empty");
    rd(2'd0, 0, "R3 stays clear later");
    for (int i = 0; i < DEPTH + 2; i++) rx_in(8'(i * 7), "R10 overfill");
    rd(2'd0, 0, "R10 count capped");
    rd(2'd3, 1, "R9 byte read");
    wr(2'd0, 0, 32'h0000_0100, "R11 only bit8");
    rd(2'd0, 0, "R11 bit9 kept");
    wr(2'd1, 0, 32'h0, "R5 mask zero");
    idle("R5 irq falls");
    idle("R5 irq low");
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit s, w, b;
      logic [1:0] a;
      logic [31:0] d;
      r = $urandom_range(0, 99);
      s = (r < 55);
      w = $urandom_range(0, 1);
      a = 2'($urandom_range(0, 3));
      b = $urandom_range(0, 1);
      d = $urandom;
      if (a == 2'd0 && $urandom_range(0, 3) != 0) d[9:8] = 2'b00;
      op(s, w, a, b, d, $urandom_range(0, 99) < 30, $urandom_range(0, 99) < 40,
         8'($urandom), "random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule